// File: doc/BRIEF.md
# Lockstep Five-Slot Bundle Dispatcher

This block is the dispatch stage of a wide-word machine. The compiler packs independent operations into fixed bundles of five slots: two memory-reference slots, two floating-point slots and one integer-or-branch slot. Each slot has its own valid bit. The dispatcher accepts one bundle per cycle over a ready/valid handshake and places every valid slot on the operation port of the unit that slot is wired to. It does no dependence checking, because the compiler guarantees that operations in a bundle are independent.

The functional units report stalls on individual lines. A stall from any one unit freezes the whole dispatch register. While that stall lasts, the bundle on the outputs stays as it is and the upstream handshake is held off.

A taken branch in the integer slot squashes the next bundle accepted after it. Two free-running counters track stalled cycles and the number of slots actually issued, so that issue efficiency can be measured.

Top module: `vliw_dispatch`

## Requirements
- R1: After reset every unit valid output is low, every unit operation output is zero, both counters read zero and `in_ready` is high while no unit stalls.
- R2: The slot mapping is fixed. Slot index i drives unit port i: indices 0 and 1 are memory units, 2 and 3 are floating-point units and 4 is the integer/branch unit. Operation field i is bits [8*i+7:8*i] of the flattened buses.
- R3: All valid slots of an accepted bundle appear on their unit ports together, in the cycle after the accepting clock edge. No slot is held back by another slot's contents.
- R4: A slot whose valid bit is low dispatches nothing: its unit valid output is low and its unit operation output is zero.
- R5: While any bit of `unit_stall` is high, `in_ready` is low and every unit output keeps its value at the following edge.
- R6: In a cycle with no stall and no accepted bundle, all unit valid outputs go low at the next edge.
- R7: When an accepted bundle has slot 4 valid and `in_br_taken` high, its own slots still dispatch, and the next bundle accepted after it dispatches as fully empty. Idle and stalled cycles in between do not cancel the squash.
- R8: `in_br_taken` has no effect when slot 4 of the same bundle is invalid, and has no effect when it comes with a bundle that is itself squashed.
- R9: `stall_cnt` increases by one at every clock edge where any unit stall line is high, and otherwise holds.
- R10: `issue_cnt` increases by the number of valid slots of each dispatched bundle. Squashed bundles and empty slots add nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A bundle is offered |
| in_ready | output | 1 | Dispatcher can accept a bundle this cycle |
| in_slot_vld | input | 5 | Per-slot valid bits of the offered bundle |
| in_slot_op | input | 40 | Per-slot operation fields, 8 bits each |
| in_br_taken | input | 1 | Integer slot holds a taken branch |
| unit_stall | input | 5 | Stall request from each functional unit |
| unit_vld | output | 5 | Operation valid to each functional unit |
| unit_op | output | 40 | Operation field to each functional unit |
| stall_cnt | output | 16 | Count of stalled cycles |
| issue_cnt | output | 16 | Count of issued non-empty slots |

## Verification
The hardest case to reach is a squash that is still pending while the pipeline is frozen or idle. The bench first accepts a taken-branch bundle, then raises a single unit's stall for several cycles and leaves the input idle for a cycle. Only after that does it offer a full bundle that carries its own taken branch, and it checks that this bundle comes out empty, adds nothing to the issue count, and does not squash the bundle after it. Every cycle is compared against a cycle model kept in the bench, including the hold behaviour for each of the five stall lines taken one at a time.

// File: rtl/vliw_pkg.sv
package vliw_pkg;
  localparam int NSLOT    = 5;
  localparam int INT_SLOT = 4;

  // number of set bits in a slot mask
  function automatic logic [2:0] slot_count(input logic [NSLOT-1:0] m);
    logic [2:0] c;
    c = '0;
    for (int i = 0; i < NSLOT; i++) c = c + {2'b00, m[i]};
    return c;
  endfunction

  // next value of the squash flag after an accepted bundle
  function automatic logic next_squash(input logic pend, input logic int_vld,
                                       input logic taken);
    return pend ? 1'b0 : (int_vld & taken);
  endfunction
endpackage

// File: rtl/vliw_issue_ctrl.sv
module vliw_issue_ctrl
  import vliw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSLOT-1:0] unit_stall,
  input  logic             in_valid,
  input  logic             int_vld,
  input  logic             br_taken,
  output logic             stall_any,
  output logic             in_ready,
  output logic             advance,
  output logic             accept,
  output logic             kill
);
  logic squash_pend;

  assign stall_any = |unit_stall;
  assign advance   = !stall_any;
  assign in_ready  = advance;
  assign accept    = in_valid && in_ready;
  assign kill      = accept && squash_pend;

  always_ff @(posedge clk) begin
    if (!rst_n)      squash_pend <= 1'b0;
    else if (accept) squash_pend <= next_squash(squash_pend, int_vld, br_taken);
  end

  // a pending squash survives cycles without an accepted bundle
  assert_squash_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept) |=> $stable(squash_pend));
  // a squashed bundle never arms another squash
  assert_no_chain_R8: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> !squash_pend);
endmodule

// File: rtl/vliw_slot_reg.sv
module vliw_slot_reg #(
  parameter int OPW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           advance,
  input  logic           ld_vld,
  input  logic [OPW-1:0] ld_op,
  output logic           q_vld,
  output logic [OPW-1:0] q_op
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_vld <= 1'b0;
      q_op  <= '0;
    end else if (advance) begin
      q_vld <= ld_vld;
      q_op  <= ld_vld ? ld_op : '0;
    end
  end

  assert_empty_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !q_vld |-> (q_op == '0));
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> ($stable(q_vld) && $stable(q_op)));
endmodule

// File: rtl/vliw_perf_cnt.sv
module vliw_perf_cnt
  import vliw_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stall_any,
  input  logic             advance,
  input  logic [NSLOT-1:0] issued,
  output logic [CW-1:0]    stall_cnt,
  output logic [CW-1:0]    issue_cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stall_cnt <= '0;
      issue_cnt <= '0;
    end else begin
      if (stall_any) stall_cnt <= stall_cnt + 1'b1;
      if (advance)   issue_cnt <= issue_cnt + CW'(slot_count(issued));
    end
  end

  assert_stall_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stall_any |=> (stall_cnt == $past(stall_cnt) + 1'b1));
  assert_issue_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(issue_cnt));
endmodule

// File: rtl/vliw_dispatch.sv
module vliw_dispatch
  import vliw_pkg::*;
#(
  parameter int OPW = 8,
  parameter int CW  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [NSLOT-1:0]     in_slot_vld,
  input  logic [NSLOT*OPW-1:0] in_slot_op,
  input  logic                 in_br_taken,
  input  logic [NSLOT-1:0]     unit_stall,
  output logic [NSLOT-1:0]     unit_vld,
  output logic [NSLOT*OPW-1:0] unit_op,
  output logic [CW-1:0]        stall_cnt,
  output logic [CW-1:0]        issue_cnt
);
  logic             stall_any, advance, accept, kill;
  logic [NSLOT-1:0] issued;

  vliw_issue_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .unit_stall (unit_stall),
    .in_valid   (in_valid),
    .int_vld    (in_slot_vld[INT_SLOT]),
    .br_taken   (in_br_taken),
    .stall_any  (stall_any),
    .in_ready   (in_ready),
    .advance    (advance),
    .accept     (accept),
    .kill       (kill)
  );

  // slots that really go out at this edge
  assign issued = (accept && !kill) ? in_slot_vld : '0;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    vliw_slot_reg #(.OPW(OPW)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (advance),
      .ld_vld  (issued[g]),
      .ld_op   (in_slot_op[g*OPW +: OPW]),
      .q_vld   (unit_vld[g]),
      .q_op    (unit_op[g*OPW +: OPW])
    );
  end

  vliw_perf_cnt #(.CW(CW)) u_perf (
    .clk       (clk),
    .rst_n     (rst_n),
    .stall_any (stall_any),
    .advance   (advance),
    .issued    (issued),
    .stall_cnt (stall_cnt),
    .issue_cnt (issue_cnt)
  );

  assert_ready_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|unit_stall) |-> !in_ready);
  assert_lockstep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !kill) |=> (unit_vld == $past(in_slot_vld)));
  assert_bubble_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|unit_stall) && !in_valid) |=> (unit_vld == '0));
  assert_squash_R7: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> (unit_vld == '0));
endmodule

// File: tb/test_vliw_dispatch.sv
module test_vliw_dispatch;
  localparam int N = 5;
  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           in_valid;
  logic           in_ready;
  logic [N-1:0]   in_slot_vld;
  logic [N*W-1:0] in_slot_op;
  logic           in_br_taken;
  logic [N-1:0]   unit_stall;
  logic [N-1:0]   unit_vld;
  logic [N*W-1:0] unit_op;
  logic [15:0]    stall_cnt;
  logic [15:0]    issue_cnt;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench-side model state
  logic [N-1:0]   m_vld;
  logic [N*W-1:0] m_op;
  logic           m_squash;
  int             m_stall;
  int             m_issue;

  always #10 clk = ~clk;

  vliw_dispatch i_vliw_dispatch (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_slot_vld(in_slot_vld), .in_slot_op(in_slot_op), .in_br_taken(in_br_taken),
    .unit_stall(unit_stall), .unit_vld(unit_vld), .unit_op(unit_op),
    .stall_cnt(stall_cnt), .issue_cnt(issue_cnt)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int ones(logic [N-1:0] m);
    int c = 0;
    for (int i = 0; i < N; i++) if (m[i]) c++;
    return c;
  endfunction

  // one cycle: drive, predict, compare after the edge
  task automatic step(string tag, bit v, logic [N-1:0] sv, logic [N*W-1:0] op,
                      bit br, logic [N-1:0] st);
    @(negedge clk);
    in_valid = v; in_slot_vld = sv; in_slot_op = op; in_br_taken = br; unit_stall = st;
    #1;
    check({tag, " R5 ready"}, 64'(in_ready), 64'(st == '0));
    if (st != '0) begin
      m_stall++;
    end else if (v) begin
      if (m_squash) begin
        m_vld = '0; m_op = '0; m_squash = 1'b0;
      end else begin
        m_vld = sv;
        for (int i = 0; i < N; i++) m_op[i*W +: W] = sv[i] ? op[i*W +: W] : '0;
        m_squash = sv[4] & br;
        m_issue += ones(sv);
      end
    end else begin
      m_vld = '0; m_op = '0;
    end
    @(posedge clk); #1;
    check({tag, " unit_vld"}, 64'(unit_vld), 64'(m_vld));
    check({tag, " unit_op"},  64'(unit_op),  64'(m_op));
    check({tag, " R9 stall_cnt"}, 64'(stall_cnt), 64'(m_stall));
    check({tag, " R10 issue_cnt"}, 64'(issue_cnt), 64'(m_issue));
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 0; in_slot_vld = '0; in_slot_op = '0;
    in_br_taken = 0; unit_stall = '0;
    m_vld = '0; m_op = '0; m_squash = 0; m_stall = 0; m_issue = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;
    check("R1 unit_vld", 64'(unit_vld), 0);
    check("R1 unit_op", 64'(unit_op), 0);
    check("R1 counters", 64'({stall_cnt, issue_cnt}), 0);
    check("R1 ready", 64'(in_ready), 1);
  endtask

  task automatic t_mapping();
    step("R2 full bundle", 1, 5'b11111, 40'h55_44_33_22_11, 0, '0);
    check("R2 int unit op", 64'(unit_op[39:32]), 64'h55);
    check("R2 mem0 unit op", 64'(unit_op[7:0]), 64'h11);
    step("R3 back to back", 1, 5'b11111, 40'hA5_A4_A3_A2_A1, 0, '0);
  endtask

  task automatic t_empty();
    step("R4 fp only", 1, 5'b01100, 40'hFF_EE_DD_CC_BB, 0, '0);
    step("R4 mem1 int", 1, 5'b10010, 40'h19_28_37_46_55, 0, '0);
    step("R4 all empty", 1, 5'b00000, 40'h12_34_56_78_9A, 0, '0);
  endtask

  task automatic t_idle();
    step("R6 prime", 1, 5'b10101, 40'h01_02_03_04_05, 0, '0);
    step("R6 idle", 0, 5'b11111, 40'hDE_AD_BE_EF_00, 0, '0);
  endtask

  task automatic t_stall();
    for (int u = 0; u < N; u++) begin
      step("R5 load", 1, 5'b11111, {8'(u), 8'h70, 8'h60, 8'h50, 8'h40}, 0, '0);
      step("R5 single stall", 1, 5'b00001, 40'hC0_C1_C2_C3_C4, 0, N'(1) << u);
      step("R5 stall again", 0, 5'b00000, '0, 0, N'(1) << u);
      step("R5 release", 1, 5'b00110, 40'h00_00_E3_E2_00, 0, '0);
    end
    step("R9 all stall", 1, 5'b11111, 40'h1, 0, 5'b11111);
  endtask

  task automatic t_branch();
    step("R7 branch bundle", 1, 5'b11011, 40'hB0_00_21_20_10, 1, '0);
    step("R7 stall while pending", 1, 5'b11111, 40'h9, 0, 5'b01000);
    step("R7 stall 2", 1, 5'b11111, 40'h9, 0, 5'b01000);
    step("R7 idle while pending", 0, 5'b11111, 40'h9, 0, '0);
    step("R8 squashed carries branch", 1, 5'b11111, 40'h6A_6B_6C_6D_6E, 1, '0);
    step("R8 after squash", 1, 5'b11111, 40'h7A_7B_7C_7D_7E, 0, '0);
    step("R8 taken without int slot", 1, 5'b01111, 40'h8A_8B_8C_8D_8E, 1, '0);
    step("R8 next kept", 1, 5'b10001, 40'h9A_9B_9C_9D_9E, 0, '0);
    step("R7 branch again", 1, 5'b10000, 40'hBB_00_00_00_00, 1, '0);
    step("R7 squashed next", 1, 5'b11111, 40'hCA_CB_CC_CD_CE, 0, '0);
    step("R7 resumed", 1, 5'b11111, 40'hDA_DB_DC_DD_DE, 0, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_mapping();
    t_empty();
    t_idle();
    t_stall();
    t_branch();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule